// File: doc/BRIEF.md
# Fly-by DMA Channel Controller

This block is a single-channel DMA engine for a shared system bus that uses separate read and write strobes for memory and for I/O. Software programs a start memory address, a unit count, a direction and a hold policy, then arms the channel. Each time the peripheral asks for service, the engine requests the bus from the processor. Once the bus is granted, it runs fly-by cycles. In a fly-by cycle only the memory address is driven, and an I/O strobe and the opposite memory strobe fire together, so one datum passes straight between the peripheral and memory without being held inside the engine.

The hold policy sets how long the processor is kept off the bus. In single mode the engine gives the bus back after every unit. In burst mode it keeps the bus for up to a programmed number of units. A long block is therefore split into many short grants, and the processor is never shut out for the whole block.

Top module: `flyby_dma`

## Requirements
- R1: While reset is asserted and in the cycle after it, hold_req, dev_ack, bus_oe, all four strobes, busy and done are low.
- R2: Once armed, the engine raises hold_req only while dev_req is high. It drives bus_oe, dev_ack and the strobes only while hold_ack is high.
- R3: Control bits [1:0] select the direction. Code 00 (device to memory) pulses io_rd and mem_wr together. Code 01 (memory to device) pulses mem_rd and io_wr together. No other strobe combination ever appears.
- R4: A control write whose direction code is 10 or 11 (memory to memory) is dropped as a whole: direction, mode and burst length all keep their previous values.
- R5: When control bit [2] is 0 (single mode), each grant carries exactly one transfer and hold_req then falls.
- R6: When control bit [2] is 1 (burst mode), each grant carries up to L transfers, where L is control bits [3+BLEN_W-1:3]. L = 0 acts as 1.
- R7: Exactly the programmed number of units is moved. The address starts at the programmed value and rises by one per unit, wrapping modulo 2^ADDR_W.
- R8: After the last unit, done rises, the bus is released and busy falls. The next start clears done.
- R9: If dev_req falls during a burst, the grant ends after the transfer in progress. The rest of the block waits for the next request.
- R10: While busy, register writes and starts are ignored.
- R11: Each strobe lasts one clock. The address and dev_ack are valid in the clock before the strobe and stay unchanged until the strobe ends.
- R12: A start (select 3) with a programmed count of zero leaves the channel idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 start |
| cfg_wdata | input | DATA_W | Register write data |
| dev_req | input | 1 | Peripheral service request |
| dev_ack | output | 1 | Peripheral acknowledge during a fly-by cycle |
| hold_req | output | 1 | Bus request to the processor |
| hold_ack | input | 1 | Bus grant from the processor |
| bus_oe | output | 1 | Engine is driving the address bus |
| bus_addr | output | ADDR_W | Memory address (zero when not driving) |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| busy | output | 1 | Channel armed or transferring |
| done | output | 1 | Sticky terminal-count flag |

## Verification
The bench builds the engine with an 8-bit address, a 10-bit count and a 4-bit burst-length field. The narrow address lets a five-unit block starting at 0xFE show the wrap to zero. The 4-bit length field makes the zero-length case and bursts both longer and shorter than the block cheap to reach. With these widths every grant split, including a burst cut short by a dropped request, completes within a few hundred cycles.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_REQ,
        ST_SETUP,
        ST_STRB,
        ST_REL
    } seq_state_e;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_GO   = 2'd3;

    localparam logic [1:0] DIR_DEV2MEM = 2'b00;
    localparam logic [1:0] DIR_MEM2DEV = 2'b01;

    typedef struct packed {
        logic io_rd;
        logic io_wr;
        logic mem_rd;
        logic mem_wr;
    } strobe_t;

    function automatic logic dir_legal(logic [1:0] code);
        return (code == DIR_DEV2MEM) || (code == DIR_MEM2DEV);
    endfunction

    function automatic strobe_t strobes_for(logic mem2dev);
        strobe_t s;
        s.io_rd  = !mem2dev;
        s.mem_wr = !mem2dev;
        s.mem_rd = mem2dev;
        s.io_wr  = mem2dev;
        return s;
    endfunction

endpackage

// File: rtl/flyby_dma_regs.sv
module flyby_dma_regs
    import flyby_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int BLEN_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idle,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [CNT_W-1:0]  prog_cnt,
    output logic              prog_m2d,
    output logic              prog_burst,
    output logic [BLEN_W-1:0] prog_blen,
    output logic              start
);

    localparam int BLEN_LSB = 3;

    logic wr_ok;
    assign wr_ok = cfg_we && idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_addr  <= '0;
            prog_cnt   <= '0;
            prog_m2d   <= 1'b0;
            prog_burst <= 1'b0;
            prog_blen  <= '0;
        end else if (wr_ok) begin
            case (cfg_sel)
                SEL_ADDR: prog_addr <= cfg_wdata[ADDR_W-1:0];
                SEL_CNT:  prog_cnt  <= cfg_wdata[CNT_W-1:0];
                SEL_CTRL: begin
                    if (dir_legal(cfg_wdata[1:0])) begin
                        prog_m2d   <= cfg_wdata[0];
                        prog_burst <= cfg_wdata[2];
                        prog_blen  <= cfg_wdata[BLEN_LSB +: BLEN_W];
                    end
                end
                default: ;
            endcase
        end
    end

    assign start = wr_ok && (cfg_sel == SEL_GO) && (prog_cnt != '0);

endmodule

// File: rtl/flyby_dma_seq.sv
module flyby_dma_seq
    import flyby_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int BLEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [CNT_W-1:0]  prog_cnt,
    input  logic              prog_m2d,
    input  logic              prog_burst,
    input  logic [BLEN_W-1:0] prog_blen,
    input  logic              dev_req,
    input  logic              hold_ack,
    output logic              hold_req,
    output logic              dev_ack,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] bus_addr,
    output strobe_t           strb,
    output logic              busy,
    output logic              done
);

    localparam int GW = BLEN_W + 1;

    seq_state_e        state;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  remain;
    logic [GW-1:0]     in_grant;
    logic [GW-1:0]     blen_eff;
    logic [GW-1:0]     in_grant_nx;
    logic              m2d;
    logic              burst;
    logic              last;
    logic              grant_end;

    assign in_grant_nx = in_grant + 1'b1;
    assign last        = (remain == CNT_W'(1));
    assign grant_end   = last || !burst || (in_grant_nx >= blen_eff) || !dev_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            remain   <= '0;
            in_grant <= '0;
            blen_eff <= GW'(1);
            m2d      <= 1'b0;
            burst    <= 1'b0;
            done     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    cur_addr <= prog_addr;
                    remain   <= prog_cnt;
                    m2d      <= prog_m2d;
                    burst    <= prog_burst;
                    blen_eff <= (prog_blen == '0) ? GW'(1) : {1'b0, prog_blen};
                    done     <= 1'b0;
                    state    <= ST_ARMED;
                end
                ST_ARMED: if (dev_req) begin
                    in_grant <= '0;
                    state    <= ST_REQ;
                end
                ST_REQ: if (hold_ack) state <= ST_SETUP;
                ST_SETUP: state <= ST_STRB;
                ST_STRB: begin
                    cur_addr <= cur_addr + 1'b1;
                    remain   <= remain - 1'b1;
                    in_grant <= in_grant_nx;
                    if (last) done <= 1'b1;
                    state <= grant_end ? ST_REL : ST_SETUP;
                end
                ST_REL: if (!hold_ack) state <= (remain == '0) ? ST_IDLE : ST_ARMED;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        hold_req = (state == ST_REQ) || (state == ST_SETUP) || (state == ST_STRB);
        bus_oe   = (state == ST_SETUP) || (state == ST_STRB);
        dev_ack  = bus_oe;
        bus_addr = bus_oe ? cur_addr : '0;
        strb     = (state == ST_STRB) ? strobes_for(m2d) : '0;
        busy     = (state != ST_IDLE);
    end

endmodule

// File: rtl/flyby_dma.sv
module flyby_dma
    import flyby_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int BLEN_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              dev_req,
    output logic              dev_ack,
    output logic              hold_req,
    input  logic              hold_ack,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              io_rd,
    output logic              io_wr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              busy,
    output logic              done
);

    logic [ADDR_W-1:0] prog_addr;
    logic [CNT_W-1:0]  prog_cnt;
    logic              prog_m2d;
    logic              prog_burst;
    logic [BLEN_W-1:0] prog_blen;
    logic              start;
    strobe_t           strb;

    flyby_dma_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BLEN_W(BLEN_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst(rst), .idle(!busy),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .prog_addr(prog_addr), .prog_cnt(prog_cnt), .prog_m2d(prog_m2d),
        .prog_burst(prog_burst), .prog_blen(prog_blen), .start(start)
    );

    flyby_dma_seq #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BLEN_W(BLEN_W)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .prog_addr(prog_addr), .prog_cnt(prog_cnt), .prog_m2d(prog_m2d),
        .prog_burst(prog_burst), .prog_blen(prog_blen),
        .dev_req(dev_req), .hold_ack(hold_ack),
        .hold_req(hold_req), .dev_ack(dev_ack), .bus_oe(bus_oe),
        .bus_addr(bus_addr), .strb(strb), .busy(busy), .done(done)
    );

    assign io_rd  = strb.io_rd;
    assign io_wr  = strb.io_wr;
    assign mem_rd = strb.mem_rd;
    assign mem_wr = strb.mem_wr;

endmodule

// File: rtl/flyby_dma_chk.sv
module flyby_dma_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              dev_ack,
    input logic              hold_req,
    input logic              hold_ack,
    input logic              bus_oe,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              done
);

    logic any_strb;
    assign any_strb = io_rd || io_wr || mem_rd || mem_wr;

    // R2: nothing is driven on the bus without both request and grant
    a_r2_drive_needs_grant: assert property (@(posedge clk) disable iff (rst)
        (bus_oe || dev_ack || any_strb) |-> (hold_req && hold_ack));

    // R3: strobes only appear as one of the two legal fly-by pairs
    a_r3_paired_strobes: assert property (@(posedge clk) disable iff (rst)
        any_strb |-> ((io_rd && mem_wr && !io_wr && !mem_rd) ||
                      (io_wr && mem_rd && !io_rd && !mem_wr)));

    // R11: strobe lasts exactly one clock
    a_r11_one_clock_strobe: assert property (@(posedge clk) disable iff (rst)
        any_strb |=> !any_strb);

    // R11: address and acknowledge set up one clock ahead and held
    a_r11_setup_hold: assert property (@(posedge clk) disable iff (rst)
        any_strb |-> ($past(bus_oe) && $past(dev_ack) && $stable(bus_addr) && dev_ack));

    // R8: when done rises the bus has been handed back
    a_r8_done_releases: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (!hold_req && !bus_oe));

endmodule

bind flyby_dma flyby_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .dev_ack(dev_ack), .hold_req(hold_req),
    .hold_ack(hold_ack), .bus_oe(bus_oe), .bus_addr(bus_addr),
    .io_rd(io_rd), .io_wr(io_wr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .done(done)
);

// File: tb/test_flyby_dma.sv
module test_flyby_dma;

    localparam int AW = 8;
    localparam int CW = 10;
    localparam int BW = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic          dev_req = 1'b0;
    logic          dev_ack, hold_req, hold_ack, bus_oe;
    logic [AW-1:0] bus_addr;
    logic          io_rd, io_wr, mem_rd, mem_wr, busy, done;

    always #5 clk = ~clk;

    flyby_dma #(.ADDR_W(AW), .CNT_W(CW), .BLEN_W(BW), .DATA_W(DW)) i_flyby_dma (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dev_req(dev_req), .dev_ack(dev_ack),
        .hold_req(hold_req), .hold_ack(hold_ack), .bus_oe(bus_oe),
        .bus_addr(bus_addr), .io_rd(io_rd), .io_wr(io_wr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .busy(busy), .done(done)
    );

    // processor model: grants one clock after the request, releases likewise
    always_ff @(posedge clk) hold_ack <= rst ? 1'b0 : hold_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // monitor state
    int            xfers, grants, in_g, max_g, addr_err, pat_err, tim_err, grant_err;
    logic [AW-1:0] exp_addr;
    logic          exp_m2d;
    logic          prev_req, prev_oe, prev_ack, prev_any;
    logic [AW-1:0] prev_addr;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
        logic [1:0]    dir;
        logic          burst;
        logic [BW-1:0] blen;
        logic [7:0]    grants;
        logic [7:0]    maxg;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t TBL [NV] = '{
        '{8'h10, 10'd3,  2'b00, 1'b0, 4'd0, 8'd3, 8'd1},
        '{8'h20, 10'd10, 2'b01, 1'b1, 4'd4, 8'd3, 8'd4},
        '{8'hFE, 10'd5,  2'b00, 1'b1, 4'd8, 8'd1, 8'd5},
        '{8'h00, 10'd7,  2'b01, 1'b1, 4'd0, 8'd7, 8'd1},
        '{8'h40, 10'd6,  2'b00, 1'b1, 4'd3, 8'd2, 8'd3},
        '{8'h80, 10'd1,  2'b01, 1'b0, 4'd0, 8'd1, 8'd1}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (hold_req && !prev_req) begin
                grants++;
                in_g = 0;
            end
            if (io_rd || io_wr || mem_rd || mem_wr) begin
                xfers++;
                in_g++;
                if (in_g > max_g) max_g = in_g;
                if (bus_addr !== exp_addr) addr_err++;
                exp_addr = exp_addr + 1'b1;
                if (exp_m2d) begin
                    if (!(mem_rd && io_wr && !io_rd && !mem_wr)) pat_err++;
                end else begin
                    if (!(io_rd && mem_wr && !io_wr && !mem_rd)) pat_err++;
                end
                if (!prev_oe || !prev_ack || prev_any || (prev_addr !== bus_addr)) tim_err++;
            end
            if ((bus_oe || dev_ack) && !hold_ack) grant_err++;
            prev_req  = hold_req;
            prev_oe   = bus_oe;
            prev_ack  = dev_ack;
            prev_addr = bus_addr;
            prev_any  = io_rd || io_wr || mem_rd || mem_wr;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [DW-1:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        tick();
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic setup(input logic [AW-1:0] a, input logic [CW-1:0] c,
                         input logic [1:0] dir, input logic b, input logic [BW-1:0] l);
        wr(2'd0, DW'(a));
        wr(2'd1, DW'(c));
        wr(2'd2, DW'({l, b, dir}));
        exp_addr = a;
    endtask

    task automatic go();
        xfers = 0; grants = 0; in_g = 0; max_g = 0;
        addr_err = 0; pat_err = 0; tim_err = 0; grant_err = 0;
        wr(2'd3, '0);
    endtask

    task automatic execute(input int n, input int g, input int mg, input string tag);
        int waited;
        dev_req = 1'b1;
        waited = 0;
        while (!(done && !busy) && waited < 3000) begin
            tick();
            waited++;
        end
        dev_req = 1'b0;
        repeat (3) tick();
        chk(waited < 3000, {tag, " R8 completion"}, waited, 3000);
        chk(xfers == n, {tag, " R7 unit count"}, xfers, n);
        chk(addr_err == 0, {tag, " R7 address sequence"}, addr_err, 0);
        chk(pat_err == 0, {tag, " R3 strobe pair"}, pat_err, 0);
        chk(tim_err == 0, {tag, " R11 setup/hold"}, tim_err, 0);
        chk(grant_err == 0, {tag, " R2 drive without grant"}, grant_err, 0);
        chk(grants == g, {tag, " R5/R6 grant count"}, grants, g);
        chk(max_g == mg, {tag, " R5/R6 units per grant"}, max_g, mg);
        chk(done && !busy && !hold_req, {tag, " R8 done and released"},
            {done, busy, hold_req}, 3'b100);
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        exp_addr = '0; exp_m2d = 1'b0;
        prev_req = 1'b0; prev_oe = 1'b0; prev_ack = 1'b0; prev_any = 1'b0; prev_addr = '0;
        xfers = 0; grants = 0; in_g = 0; max_g = 0;
        addr_err = 0; pat_err = 0; tim_err = 0; grant_err = 0;

        repeat (3) tick();
        chk(!hold_req && !dev_ack && !bus_oe && !busy && !done &&
            !io_rd && !io_wr && !mem_rd && !mem_wr, "R1 outputs in reset", busy, 0);
        rst = 1'b0;
        tick();
        chk(!hold_req && !bus_oe && !busy && !done, "R1 outputs after reset",
            {hold_req, bus_oe, busy, done}, 0);

        // table-driven runs
        for (int i = 0; i < NV; i++) begin
            setup(TBL[i].addr, TBL[i].cnt, TBL[i].dir, TBL[i].burst, TBL[i].blen);
            exp_m2d = TBL[i].dir[0];
            go();
            execute(int'(TBL[i].cnt), int'(TBL[i].grants), int'(TBL[i].maxg),
                    $sformatf("vec%0d", i));
        end

        // R12: start with zero count stays idle and keeps done
        setup(8'h33, 10'd0, 2'b00, 1'b0, 4'd0);
        go();
        tick();
        chk(!busy && done, "R12 zero count start ignored", {busy, done}, 2'b01);

        // R4: memory-to-memory control code rejected, earlier settings stay
        setup(8'h30, 10'd2, 2'b00, 1'b0, 4'd0);
        wr(2'd2, DW'({4'd4, 1'b1, 2'b10}));
        wr(2'd2, DW'({4'd4, 1'b1, 2'b11}));
        exp_m2d = 1'b0;
        go();
        execute(2, 2, 1, "R4");

        // R2 and R10: armed without request, writes ignored while busy
        setup(8'h50, 10'd3, 2'b01, 1'b1, 4'd2);
        exp_m2d = 1'b1;
        go();
        repeat (5) tick();
        chk(busy && !hold_req && !bus_oe, "R2 no request before device asks",
            {busy, hold_req, bus_oe}, 3'b100);
        wr(2'd0, DW'(8'hA0));
        wr(2'd1, DW'(10'd9));
        wr(2'd2, DW'({4'd1, 1'b0, 2'b00}));
        wr(2'd3, '0);
        execute(3, 2, 2, "R10");

        // R9: device drops request in the middle of a burst
        begin
            int seen;
            int waited;
            setup(8'h60, 10'd8, 2'b00, 1'b1, 4'd8);
            exp_m2d = 1'b0;
            go();
            dev_req = 1'b1;
            seen = 0;
            waited = 0;
            while (seen < 3 && waited < 500) begin
                tick();
                waited++;
                if (io_rd) seen++;
            end
            dev_req = 1'b0;
            repeat (8) tick();
            chk(xfers == 3, "R9 burst cut after current unit", xfers, 3);
            chk(busy && !hold_req && !done, "R9 bus released, block pending",
                {busy, hold_req, done}, 3'b100);
            execute(8, 2, 5, "R9");
        end

        // R8: next start clears done
        setup(8'h70, 10'd2, 2'b01, 1'b0, 4'd0);
        go();
        chk(!done && busy, "R8 done cleared by start", {done, busy}, 2'b01);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule